// File: doc/BRIEF.md
# Counter-Addressed OTP Programming Port

This block is the byte-wide programming front end of an on-chip one-time-programmable memory. It has no address pins. The word being accessed is chosen by an internal address counter. A level-sensitive clear input returns the counter to zero. Each rising edge of a slow address clock moves the counter forward by one. A programmer therefore clears the counter once, then walks through the array, programming or verifying one byte per address step.

Three active-low strobes choose the operation:
- **Chip enable** gates every operation.
- **Output enable** turns the data bus around, so the block drives the stored byte outward.
- **Program strobe** writes the inbound byte on its falling edge.

A programmed cell can only move from 1 to 0. A second write therefore stores the AND of the old and new bytes, and a verify read shows any overwrite that failed. A digital mode input stands in for the high-voltage mode select. When the mode input is low, the array is read-only.

The strobes pace every transfer, and there is no valid/ready handshake. The array cannot stall, so there is no back-pressure. A strobe edge is always consumed on the system clock edge that samples it.

Top module: `otp_prog_port`

## Requirements
- R1: While `addr_clr` is high the address counter is held at 0, and this takes priority over an address clock rising edge sampled in the same cycle.
- R2: Each rising edge of `addr_clk`, sampled on `clk`, advances the counter by exactly one. Holding `addr_clk` high, or holding it low, leaves the counter unchanged.
- R3: After address DEPTH-1, the next step wraps the counter to address 0.
- R4: With `ce_n`=0 and `oe_n`=0, `bus_drive` is 1 and `bus_out` shows the word at the counter address in the same cycle. Otherwise `bus_drive` is 0 and `bus_out` is 0.
- R5: A falling edge of `pgm_n`, with `ce_n`=0, `oe_n`=1 and `prog_en`=1, programs the byte on `bus_in` into the word at the counter address.
- R6: Programming only clears bits. The stored word becomes the old word AND `bus_in`, and no bit ever returns from 0 to 1 except through reset.
- R7: When `oe_n` and `pgm_n` are both low, the write is ignored and the bus stays in output mode.
- R8: With `ce_n`=1, no read and no write take place.
- R9: With `prog_en`=0, the program strobe is ignored. Reads are still allowed.
- R10: After reset, the counter is 0 and every word reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low synchronous reset; blanks the array |
| prog_en | input | 1 | Mode select: 1 allows programming, 0 is read-only |
| addr_clr | input | 1 | Active-high level clear of the address counter |
| addr_clk | input | 1 | Address clock; each rising edge steps the counter |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; sets the bus direction |
| pgm_n | input | 1 | Program strobe, active low; writes on its falling edge |
| bus_in | input | 8 | Inbound data byte |
| bus_out | output | 8 | Outbound data byte, 0 when not driving |
| bus_drive | output | 1 | 1 while the bus is in output mode |

## Verification
Assertions are checked on every cycle for the following:
- Counter clearing and the clear priority.
- Single-step advance and the wrap.
- Bits only ever falling, in every word.
- A write never coinciding with output mode, a disabled chip or read-only mode.

The bench scenarios are what show that the bytes seen at the port match a model of the array. This means the right address was programmed, the AND result appears on verify, and ignored strobes leave the stored data untouched. Those facts can only be shown by reading the data back through the bus.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] word_t;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_PROG} op_t;
endpackage

// File: rtl/otp_addr_ctr.sv
module otp_addr_ctr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_clr,
  input  logic          addr_clk,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic aclk_q;
  logic step;

  assign step = addr_clk & ~aclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aclk_q <= 1'b0;
      addr   <= '0;
    end else begin
      aclk_q <= addr_clk;
      if (addr_clr)        addr <= '0;
      else if (step) begin
        if (addr == LAST)  addr <= '0;
        else               addr <= addr + 1'b1;
      end
    end
  end

  // R1
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |=> addr == '0);
  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_clr && step && addr != LAST) |=> addr == AW'($past(addr) + 1'b1));
  // R2
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_clr && !step) |=> $stable(addr));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_clr && step && addr == LAST) |=> addr == '0);
endmodule

// File: rtl/otp_bus_ctl.sv
module otp_bus_ctl
  import otp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_en,
  input  logic ce_n,
  input  logic oe_n,
  input  logic pgm_n,
  output logic drive,
  output logic wr_en
);
  logic pgm_q;
  logic pgm_fall;
  op_t  op;

  assign pgm_fall = pgm_q & ~pgm_n;

  always_ff @(posedge clk) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  always_comb begin
    op = OP_IDLE;
    if (!ce_n) begin
      if (!oe_n)                    op = OP_READ;
      else if (pgm_fall && prog_en) op = OP_PROG;
    end
  end

  assign drive = (op == OP_READ);
  assign wr_en = (op == OP_PROG);

  // R8
  chip_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!drive && !wr_en));
  // R7
  no_write_in_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !wr_en);
  // R9
  read_only_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> !wr_en);
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  output word_t         rdata
);
  word_t cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                            cells[g] <= '1;
      else if (wr_en && addr == AW'(g))      cells[g] <= cells[g] & wdata;
    end

    // R6
    bits_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cells[g] & ~$past(cells[g])) == '0);
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_en,
  input  logic       addr_clr,
  input  logic       addr_clk,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       pgm_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_drive
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] addr;
  logic          wr_en;
  logic          drive;
  word_t         rd_word;

  otp_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .addr_clr(addr_clr), .addr_clk(addr_clk), .addr(addr)
  );

  otp_bus_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .drive(drive), .wr_en(wr_en)
  );

  otp_cell_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(bus_in),
    .rdata(rd_word)
  );

  assign bus_drive = drive;
  assign bus_out   = drive ? rd_word : '0;

  // R4
  out_zero_when_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> bus_out == '0);
  // R7
  write_excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !bus_drive);
endmodule

// File: tb/otp_prog_port_tb.sv
module otp_prog_port_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b1, addr_clr = 1'b0, addr_clk = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic bus_drive;

  int total = 0, bad = 0;
  int ptr = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  otp_prog_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .addr_clr(addr_clr),
    .addr_clk(addr_clk), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse();
    addr_clk = 1'b1; @(negedge clk);
    addr_clk = 1'b0; @(negedge clk);
    ptr = (ptr + 1) % DEPTH;
  endtask

  task automatic prog(input logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b1; bus_in = v; pgm_n = 1'b0;
    @(negedge clk);
    pgm_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    if (prog_en) model[ptr] = model[ptr] & v;
  endtask

  task automatic read_chk(input string req);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk(req, {7'b0, bus_drive}, 8'h01);
    chk(req, bus_out, model[ptr]);
    oe_n = 1'b1; ce_n = 1'b1; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state, R4 idle bus
    chk("R4", {7'b0, bus_drive}, 8'h00);
    chk("R4", bus_out, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin read_chk("R10"); pulse(); end
    // R3 wrapped back to address 0 after DEPTH steps
    read_chk("R3");
    // R5 program every word with a distinct pattern, then verify sweep
    for (int i = 0; i < DEPTH; i++) begin prog(8'((i * 37 + 5) ^ 8'h80)); pulse(); end
    for (int i = 0; i < DEPTH; i++) begin read_chk("R5"); pulse(); end
    // R6 overwrite only clears bits
    prog(8'hF0); read_chk("R6");
    prog(8'h3C); read_chk("R6");
    // R2 held address clock gives one step only
    addr_clk = 1'b1; repeat (5) @(negedge clk);
    addr_clk = 1'b0; @(negedge clk);
    ptr = (ptr + 1) % DEPTH;
    read_chk("R2");
    // R1 clear beats a simultaneous rising edge
    pulse(); pulse();
    addr_clr = 1'b1; addr_clk = 1'b1; @(negedge clk);
    addr_clr = 1'b0; @(negedge clk);
    addr_clk = 1'b0; @(negedge clk);
    ptr = 0;
    read_chk("R1");
    // R7 program strobe with output enabled: ignored, bus stays output
    pulse();
    ce_n = 1'b0; oe_n = 1'b0; bus_in = 8'h00; pgm_n = 1'b0; @(negedge clk);
    chk("R7", {7'b0, bus_drive}, 8'h01);
    chk("R7", bus_out, model[ptr]);
    pgm_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1; @(negedge clk);
    read_chk("R7");
    // R8 chip disabled: no write, no drive
    ce_n = 1'b1; oe_n = 1'b0; bus_in = 8'h00; pgm_n = 1'b0; @(negedge clk);
    chk("R8", {7'b0, bus_drive}, 8'h00);
    chk("R8", bus_out, 8'h00);
    pgm_n = 1'b1; oe_n = 1'b1; @(negedge clk);
    read_chk("R8");
    // R9 read-only mode ignores program strobe
    prog_en = 1'b0; pulse();
    prog(8'h00);
    read_chk("R9");
    prog_en = 1'b1;
    // R4 output enable high keeps bus as input
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R4", {7'b0, bus_drive}, 8'h00);
    chk("R4", bus_out, 8'h00);
    ce_n = 1'b1; @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule